// File: doc/BRIEF.md
# Overlapped Transfer and Compute Sequencer

This block schedules a kernel that runs over and over on one single-port on-chip memory. Each kernel run has two concurrent stages. The transfer stage first drains the previous results from an output register set into memory, then fills an input register set with the next operands. The compute stage starts an external datapath on the operand set filled in the run before and waits for it to finish. The register sets are double-banked. Each new run flips which bank the transfer stage uses, and the compute stage always takes the other bank.

Writes and reads share the one port, so within the transfer stage they are strictly serialized and the port is never read and written in the same cycle. A word write holds the port for a configurable number of cycles and a word read for another. Because each run waits for the slower stage, the run period is set by whichever is longer: the memory traffic or the datapath latency.

A bank's results are written back only once they exist. The first run after reset therefore only loads, the second loads and computes, and from the third run on every run writes back, loads and computes.

Top module: `ovl_ctrl`

## Requirements
- R1: After reset no memory access and no datapath start is issued. While `run` is low, `run_launch` stays low.
- R2: The first run after reset performs no write-back and issues no `dp_start`. It only loads RD_WORDS words.
- R3: From the second run on, `dp_start` is a one-cycle pulse in the cycle after `run_launch`. The second run still performs no write-back.
- R4: From the third run on, the transfer stage writes WR_WORDS words before its first read. Each word holds `mem_en`=1 and `mem_we`=1 for WR_CYC consecutive cycles, starting the cycle after launch. Word i goes to address WR_BASE+i, with `res_idx`=i and `mem_wdata` equal to `res_word`.
- R5: Read word i holds `mem_en`=1, `mem_we`=0 and address RD_BASE+i for RD_CYC cycles. `in_load` pulses on the last of those cycles with `in_idx`=i. Exactly RD_WORDS loads occur per run.
- R6: In run k (k=1 after reset), `in_bank` and `res_bank` equal (k-1) mod 2, and `dp_bank` equals k mod 2.
- R7: The spacing between consecutive `run_launch` pulses equals max(T+1, C+2). T is the transfer stage's cycle count (write cycles plus RD_WORDS·RD_CYC). C is the number of cycles from `dp_start` to the `dp_done` pulse. The C+2 term is omitted when the run has no compute.
- R8: A `dp_done` pulse that arrives while no computation is outstanding has no effect on run timing or on later starts.
- R9: Once `run` is low, no new run launches, and the memory port goes idle after the current run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Permit new kernel runs |
| run_launch | output | 1 | High in the cycle a new run begins |
| mem_en | output | 1 | Memory port access enable |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Write data, taken from `res_word` |
| res_word | input | DATA_W | Output register set word selected by `res_bank`/`res_idx` |
| res_bank | output | 1 | Output bank being drained |
| res_idx | output | IDX_W | Output word index being drained |
| in_load | output | 1 | Strobe: capture the memory read data into the input set |
| in_bank | output | 1 | Input bank being filled |
| in_idx | output | IDX_W | Input word index being filled |
| dp_start | output | 1 | One-cycle datapath start pulse |
| dp_bank | output | 1 | Bank the datapath reads and writes |
| dp_done | input | 1 | Datapath completion pulse |

## Verification
The bound checker watches the port discipline on every cycle. It checks that a read phase is never followed by a write within a run, that the address is held for the whole of a read word, that `dp_start` appears only right after a launch, and that each run delivers exactly RD_WORDS loads. The launch spacing, the first-run and second-run reductions, the bank alternation and the immunity to a stray completion depend on the whole history of runs and on the datapath latency. Only the bench's sweep of compute latencies across both sides of the memory-bound and compute-bound boundary shows those.

// File: rtl/ovl_pkg.sv
// Shared types for the overlapped transfer/compute sequencer.
// Assumes: nothing beyond the parameters of its users.
package ovl_pkg;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_WR   = 2'd1,
        XS_RD   = 2'd2
    } xfer_st_t;

    typedef enum logic {
        CS_IDLE = 1'b0,
        CS_WAIT = 1'b1
    } comp_st_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ovl_xfer_stage.sv
// Transfer stage: on launch, optionally drains WR_WORDS result words
// (WR_CYC cycles each) and then fills RD_WORDS operand words (RD_CYC cycles
// each) over one shared port. The port is never read and written together.
// Assumes: launch is only asserted while idle is high.
module ovl_xfer_stage
    import ovl_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int IDX_W    = 4,
    parameter int RD_WORDS = 10,
    parameter int WR_WORDS = 9,
    parameter int RD_CYC   = 3,
    parameter int WR_CYC   = 1,
    parameter int RD_BASE  = 0,
    parameter int WR_BASE  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              wb_req,
    output logic              idle,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [IDX_W-1:0]  word_idx,
    output logic              in_load
);
    localparam int BEAT_W = $clog2(imax(RD_CYC, WR_CYC) + 1);

    xfer_st_t          st_q;
    logic [IDX_W-1:0]  word_q;
    logic [BEAT_W-1:0] beat_q;
    logic              wr_last_beat;
    logic              rd_last_beat;
    logic              wr_last_word;
    logic              rd_last_word;

    // Position decode within the current word and phase.
    always_comb begin
        wr_last_beat = (beat_q == BEAT_W'(WR_CYC - 1));
        rd_last_beat = (beat_q == BEAT_W'(RD_CYC - 1));
        wr_last_word = (word_q == IDX_W'(WR_WORDS - 1));
        rd_last_word = (word_q == IDX_W'(RD_WORDS - 1));
    end

    // Phase sequencing: idle -> (write) -> read -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= XS_IDLE;
            word_q <= '0;
            beat_q <= '0;
        end else begin
            case (st_q)
                XS_IDLE: begin
                    if (launch) begin
                        st_q   <= wb_req ? XS_WR : XS_RD;
                        word_q <= '0;
                        beat_q <= '0;
                    end
                end
                XS_WR: begin
                    if (wr_last_beat) begin
                        beat_q <= '0;
                        if (wr_last_word) begin
                            st_q   <= XS_RD;
                            word_q <= '0;
                        end else begin
                            word_q <= word_q + 1'b1;
                        end
                    end else begin
                        beat_q <= beat_q + 1'b1;
                    end
                end
                XS_RD: begin
                    if (rd_last_beat) begin
                        beat_q <= '0;
                        if (rd_last_word) begin
                            st_q   <= XS_IDLE;
                            word_q <= '0;
                        end else begin
                            word_q <= word_q + 1'b1;
                        end
                    end else begin
                        beat_q <= beat_q + 1'b1;
                    end
                end
                default: st_q <= XS_IDLE;
            endcase
        end
    end

    // Port drive and load strobe from the current phase.
    always_comb begin
        idle     = (st_q == XS_IDLE);
        mem_en   = (st_q != XS_IDLE);
        mem_we   = (st_q == XS_WR);
        word_idx = word_q;
        in_load  = (st_q == XS_RD) && rd_last_beat;
        mem_addr = ((st_q == XS_WR) ? ADDR_W'(WR_BASE) : ADDR_W'(RD_BASE))
                   + ADDR_W'(word_q);
    end

endmodule

// File: rtl/ovl_comp_stage.sv
// Compute stage: on a launch with a filled operand bank, issues a one-cycle
// datapath start and waits for its completion pulse. A completion arriving
// while nothing is outstanding is ignored.
// Assumes: launch is only asserted while idle is high.
module ovl_comp_stage
    import ovl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic cp_req,
    input  logic dp_done,
    output logic idle,
    output logic dp_start,
    output logic fin
);
    comp_st_t st_q;
    logic     start_q;

    // Start pulse and wait-for-completion tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= CS_IDLE;
            start_q <= 1'b0;
        end else begin
            start_q <= launch && cp_req;
            case (st_q)
                CS_IDLE: if (launch && cp_req) st_q <= CS_WAIT;
                CS_WAIT: if (dp_done) st_q <= CS_IDLE;
                default: st_q <= CS_IDLE;
            endcase
        end
    end

    // Status toward the top-level launch gate.
    always_comb begin
        idle     = (st_q == CS_IDLE);
        dp_start = start_q;
        fin      = (st_q == CS_WAIT) && dp_done;
    end

endmodule

// File: rtl/ovl_ctrl.sv
// Top of the overlapped transfer/compute sequencer. Launches a run when both
// stages are idle and run is high, flips the register bank on every launch,
// and tracks per-bank validity so that write-back and compute are requested
// only for banks holding real data.
// Assumes: the external register sets capture mem data on in_load and
// present the word selected by res_bank/res_idx on res_word.
module ovl_ctrl
    import ovl_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int ADDR_W   = 8,
    parameter int RD_WORDS = 10,
    parameter int WR_WORDS = 9,
    parameter int RD_CYC   = 3,
    parameter int WR_CYC   = 1,
    parameter int RD_BASE  = 0,
    parameter int WR_BASE  = 16,
    localparam int IDX_W   = $clog2(imax(RD_WORDS, WR_WORDS) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    output logic              run_launch,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] res_word,
    output logic              res_bank,
    output logic [IDX_W-1:0]  res_idx,
    output logic              in_load,
    output logic              in_bank,
    output logic [IDX_W-1:0]  in_idx,
    output logic              dp_start,
    output logic              dp_bank,
    input  logic              dp_done
);
    logic             bank_q;
    logic [1:0]       in_vld_q;
    logic [1:0]       out_vld_q;
    logic             x_idle;
    logic             c_idle;
    logic             c_fin;
    logic             launch;
    logic             bank_nx;
    logic             wb_req;
    logic             cp_req;
    logic [IDX_W-1:0] x_idx;

    // Launch gate and per-run requests for the bank about to be used.
    always_comb begin
        launch  = run && x_idle && c_idle;
        bank_nx = ~bank_q;
        wb_req  = out_vld_q[bank_nx];
        cp_req  = in_vld_q[bank_q];
    end

    // Bank flip and validity bookkeeping for both register-set banks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q    <= 1'b1;
            in_vld_q  <= '0;
            out_vld_q <= '0;
        end else if (launch) begin
            bank_q             <= bank_nx;
            in_vld_q[bank_nx]  <= 1'b1;
            in_vld_q[bank_q]   <= 1'b0;
            out_vld_q[bank_nx] <= 1'b0;
        end else if (c_fin) begin
            out_vld_q[~bank_q] <= 1'b1;
        end
    end

    ovl_xfer_stage #(
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W),
        .RD_WORDS (RD_WORDS),
        .WR_WORDS (WR_WORDS),
        .RD_CYC   (RD_CYC),
        .WR_CYC   (WR_CYC),
        .RD_BASE  (RD_BASE),
        .WR_BASE  (WR_BASE)
    ) u_xfer (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .wb_req   (wb_req),
        .idle     (x_idle),
        .mem_en   (mem_en),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .word_idx (x_idx),
        .in_load  (in_load)
    );

    ovl_comp_stage u_comp (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .cp_req   (cp_req),
        .dp_done  (dp_done),
        .idle     (c_idle),
        .dp_start (dp_start),
        .fin      (c_fin)
    );

    // Register-set selection and write data routing.
    always_comb begin
        run_launch = launch;
        mem_wdata  = res_word;
        res_bank   = bank_q;
        res_idx    = x_idx;
        in_bank    = bank_q;
        in_idx     = x_idx;
        dp_bank    = ~bank_q;
    end

endmodule

// File: rtl/ovl_ctrl_chk.sv
// Cycle-level checker for ovl_ctrl, attached by bind below.
module ovl_ctrl_chk #(
    parameter int ADDR_W   = 8,
    parameter int RD_WORDS = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_launch,
    input logic              mem_en,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              in_load,
    input logic              dp_start
);
    localparam int LC_W = $clog2(RD_WORDS + 2);

    logic [LC_W-1:0] loads_q;
    logic            seen_q;

    // Count operand loads since the latest launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loads_q <= '0;
            seen_q  <= 1'b0;
        end else if (run_launch) begin
            loads_q <= '0;
            seen_q  <= 1'b1;
        end else if (in_load) begin
            loads_q <= loads_q + 1'b1;
        end
    end

    // R4: once reading, no write follows within the same run
    a_r4_no_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> !mem_we);

    // R5: address and direction held until the load strobe ends a read word
    a_r5_read_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we && !in_load) |=> (mem_en && !mem_we && $stable(mem_addr)));

    // R5: every completed run delivered exactly RD_WORDS loads
    a_r5_load_count: assert property (@(posedge clk) disable iff (!rst_n)
        (run_launch && seen_q) |-> (loads_q == LC_W'(RD_WORDS)));

    // R3: a datapath start follows a launch by exactly one cycle
    a_r3_start_after_launch: assert property (@(posedge clk) disable iff (!rst_n)
        dp_start |-> $past(run_launch));

    // R3: the start is a single-cycle pulse
    a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dp_start |=> !dp_start);

    // R1: the port is quiet in the cycle a run is launched
    a_r1_launch_port_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        run_launch |-> !mem_en);

endmodule

bind ovl_ctrl ovl_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .RD_WORDS (RD_WORDS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_launch (run_launch),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .in_load    (in_load),
    .dp_start   (dp_start)
);

// File: tb/ovl_ctrl_test.sv
`timescale 1ns/1ps
module ovl_ctrl_test;
    localparam int DATA_W   = 64;
    localparam int ADDR_W   = 8;
    localparam int RD_WORDS = 10;
    localparam int WR_WORDS = 9;
    localparam int RD_CYC   = 3;
    localparam int WR_CYC   = 1;
    localparam int RD_BASE  = 0;
    localparam int WR_BASE  = 16;
    localparam int IDX_W    = $clog2(((RD_WORDS > WR_WORDS) ? RD_WORDS : WR_WORDS) + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              run = 1'b0;
    logic              run_launch, mem_en, mem_we, res_bank, in_load, in_bank;
    logic              dp_start, dp_bank;
    logic              dp_done = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, res_word;
    logic [IDX_W-1:0]  res_idx, in_idx;

    int checks = 0, failures = 0;
    bit finished = 0;

    ovl_ctrl uut (
        .clk(clk), .rst_n(rst_n), .run(run), .run_launch(run_launch),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .res_word(res_word), .res_bank(res_bank),
        .res_idx(res_idx), .in_load(in_load), .in_bank(in_bank),
        .in_idx(in_idx), .dp_start(dp_start), .dp_bank(dp_bank),
        .dp_done(dp_done)
    );

    always #2 clk = ~clk;

    function automatic logic [63:0] pat(input logic b, input int i);
        return {24'hC0FFEE, 7'd0, b, 32'(i)};
    endfunction

    assign res_word = pat(res_bank, int'(res_idx));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Scenario state shared with the monitor.
    int comp_c = 1;
    bit stray_en = 0;
    int cyc = 0, run_no = 0, t_l = 0;
    int n_wcyc, n_rcyc, n_ld, first_ld, n_dp, dp_at;
    bit wr_ok, rd_ok, bank_ok, dpb_ok;
    int dp_cnt = 0;
    bit armed = 0;

    // Close the record of run k at the next launch and compare with expectations.
    task automatic finalize(input int k);
        int w, t1, ei;
        bit wb, cp;
        wb = (k >= 3);
        cp = (k >= 2);
        w  = wb ? WR_WORDS * WR_CYC : 0;
        t1 = w + RD_WORDS * RD_CYC;
        ei = cp ? (((t1 + 1) > (comp_c + 2)) ? (t1 + 1) : (comp_c + 2)) : (t1 + 1);
        check(cyc - t_l == ei, stray_en ? "R8 launch spacing with stray done" : "R7 launch spacing",
              cyc - t_l, ei);
        check(n_wcyc == w, wb ? "R4 write-back cycles" : "R2 no write-back early", n_wcyc, w);
        check(wr_ok, "R4 write order/address/data", wr_ok, 1);
        check(first_ld - t_l == w + RD_CYC, "R4 reads follow writes", first_ld - t_l, w + RD_CYC);
        check(n_ld == RD_WORDS && n_rcyc == RD_WORDS * RD_CYC, "R5 load count", n_ld, RD_WORDS);
        check(rd_ok, "R5 read timing/address/index", rd_ok, 1);
        check(bank_ok, "R6 transfer bank", bank_ok, 1);
        check(n_dp == (cp ? 1 : 0), cp ? "R3 one start per run" : "R2 no start in first run",
              n_dp, cp ? 1 : 0);
        if (cp) begin
            check(dp_at == 1, "R3 start one cycle after launch", dp_at, 1);
            check(dpb_ok, "R6 datapath bank", dpb_ok, 1);
        end
    endtask

    // Monitor plus behavioural datapath, evaluated away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            run_no = 0;
            armed  = 0;
            dp_done = 1'b0;
        end else begin
            if (run_launch) begin
                if (run_no > 0) finalize(run_no);
                run_no++;
                t_l = cyc;
                n_wcyc = 0; n_rcyc = 0; n_ld = 0; first_ld = -1000; n_dp = 0; dp_at = -1;
                wr_ok = 1; rd_ok = 1; bank_ok = 1; dpb_ok = 1;
            end
            if (mem_en && mem_we) begin
                if (cyc - t_l != 1 + n_wcyc) wr_ok = 0;
                if (int'(res_idx) != n_wcyc / WR_CYC) wr_ok = 0;
                if (int'(mem_addr) != WR_BASE + n_wcyc / WR_CYC) wr_ok = 0;
                if (mem_wdata != pat(1'((run_no - 1) % 2), n_wcyc / WR_CYC)) wr_ok = 0;
                if (res_bank != 1'((run_no - 1) % 2)) bank_ok = 0;
                n_wcyc++;
            end
            if (mem_en && !mem_we) begin
                if (int'(mem_addr) != RD_BASE + n_rcyc / RD_CYC) rd_ok = 0;
                if (in_load != ((n_rcyc % RD_CYC) == RD_CYC - 1)) rd_ok = 0;
                n_rcyc++;
            end
            if (in_load) begin
                if (n_ld == 0) first_ld = cyc;
                if (int'(in_idx) != n_ld) rd_ok = 0;
                if (in_bank != 1'((run_no - 1) % 2)) bank_ok = 0;
                n_ld++;
            end
            if (dp_start) begin
                n_dp++;
                dp_at = cyc - t_l;
                if (dp_bank != 1'(run_no % 2)) dpb_ok = 0;
            end
            // Datapath: done pulse comp_c cycles after the start cycle.
            if (dp_start) begin
                dp_cnt = comp_c;
                armed  = 1;
            end else if (armed && dp_cnt > 0) begin
                dp_cnt--;
            end
            dp_done = armed && (dp_cnt == 0);
            if (dp_done) armed = 0;
            if (stray_en && run_no == 1 && (cyc - t_l == 5 || cyc - t_l == 20)) dp_done = 1'b1;
        end
    end

    task automatic scenario(input int c, input bit stray);
        rst_n = 1'b0;
        run = 1'b0;
        comp_c = c;
        stray_en = stray;
        repeat (3) @(posedge clk);
        #1;
        check(!mem_en && !dp_start && !run_launch, "R1 quiet in reset",
              int'({mem_en, dp_start, run_launch}), 0);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        check(!run_launch && !mem_en && !dp_start, "R1 idle with run low",
              int'({run_launch, mem_en, dp_start}), 0);
        run = 1'b1;
        while (run_no < 6) @(posedge clk);
        #1;
        run = 1'b0;
        repeat (150) @(posedge clk);
        #1;
        check(run_no == 6, "R9 no launch with run low", run_no, 6);
        check(!mem_en && !run_launch, "R9 port idle after stop", int'({mem_en, run_launch}), 0);
    endtask

    initial begin
        int cs[13] = '{1, 2, 10, 28, 29, 30, 36, 37, 38, 39, 40, 55, 90};
        foreach (cs[i]) scenario(cs[i], 1'b0);
        scenario(20, 1'b1);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL R7 watchdog expired actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule